// File: doc/BRIEF.md
# Hamming ECC Compare and Correct

This block checks data read from a NAND page against its single-error-correcting Hamming code, one 512-byte data block at a time. For each block it takes two 3-byte codes. The first is the code stored in the spare area. The second is the code that the parity engine computed over the data just read. The block classifies the block as clean, as carrying one flipped data bit, as carrying an error in the code bytes alone, as uncorrectable, or as erased. When one data bit is wrong, the block reports the byte index and bit index to flip. The data buffer and the parity engine sit outside the block, and the block does not touch the data itself.

A page is opened with a start strobe that selects one of two page sizes. The short page holds one block. The long page holds up to `MAX_BLOCKS` blocks (four by default, for 2048 bytes). Blocks then arrive one per strobe, in page order. The block pulses a result for every block it accepts. It keeps a count of the corrections made on the page. It closes the page after the last block, or early when a block cannot be corrected.

Both codes are repacked into a 28-bit word before comparison:

| Field | Bits |
|-------|------|
| byte 0 | 7:0 |
| low nibble of byte 2 | 11:8 |
| byte 1 | 23:16 |
| high nibble of byte 2 | 27:24 |
| unused (zero) | 15:12 |

Top module: `hm_ecc_corrector`

## Requirements
- R1: When the stored and computed codes are equal, the result is status 0 (clean). `fixEn` is 0 and the page count does not change.
- R2: Code bytes are byte 0 = bits 7:0, byte 1 = bits 15:8 and byte 2 = bits 23:16 of each code port. The compacted difference is c = {b2[7:4], b1, b2[3:0], b0} of the two codes' XOR, and pair k is c[2k+1:2k]. When all 12 pairs hold exactly one set bit, the result is status 1 (fixed) with `fixEn` = 1. The address is a[k] = c[2k+1]. `fixByte` = a[11:3], `fixBit` = a[2:0], and the page count rises by one.
- R3: When c has exactly one set bit, the result is status 2 (code-byte error). `fixEn` is 0 and the page count rises by one.
- R4: Any other mismatch gives status 3 (uncorrectable). It closes the page with `pageDone` and `pageFail` both 1.
- R5: When the stored code is 24'hFFFFFF and differs from the computed code, the result is status 4 (erased). This check takes priority over R2 and R3. There is no correction, no count and no page failure.
- R6: In long-page mode (`longPage` = 1 at `pageStart`), blocks are numbered 0 to 3 on `resBlock`. `pageDone` pulses with the result of block 3 only.
- R7: In short-page mode (`longPage` = 0), `pageDone` pulses with the result of the first block, which has `resBlock` = 0.
- R8: `pageFixCount` holds the number of blocks of the current page with status 1 or 2. `pageStart` clears it to 0.
- R9: After an uncorrectable block, the block ignores further block strobes until the next `pageStart`.
- R10: A block strobe outside an open page gives no result and no page completion.
- R11: A result appears one clock after its block strobe, and `resValid` and `pageDone` are one-cycle pulses. Reset clears `resValid`, `fixEn`, `pageDone`, `pageFail` and `pageFixCount`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pageStart | input | 1 | Opens a page and clears the correction count |
| longPage | input | 1 | Page size, sampled at `pageStart`: 1 = MAX_BLOCKS blocks, 0 = one block |
| blockValid | input | 1 | Strobe: the codes for the next block are present |
| storedCode | input | 24 | Code read from the spare area (byte 2, byte 1, byte 0) |
| calcCode | input | 24 | Code computed over the data just read |
| resValid | output | 1 | One-cycle pulse: block result valid |
| resStatus | output | 3 | 0 clean, 1 fixed, 2 code-byte error, 3 uncorrectable, 4 erased |
| resBlock | output | 2 | Index of the block within its page |
| fixEn | output | 1 | A data bit must be flipped |
| fixByte | output | 9 | Byte index within the block to correct |
| fixBit | output | 3 | Bit index within that byte |
| pageDone | output | 1 | One-cycle pulse: page closed |
| pageFail | output | 1 | With `pageDone`: the page holds an uncorrectable block |
| pageFixCount | output | 3 | Corrections counted on the current page |

## Verification
The assertions check four rules on every cycle:
- equal codes always give a clean result;
- an all-ones stored code is never corrected;
- a page failure only appears together with an uncorrectable result and a page completion;
- the count never exceeds the block limit.

Only the bench's scenarios can show that the decoded byte and bit positions are right for each address pattern. The same holds for the order of blocks across a long page, the counted total at its close, and the silence after an early abort or outside a page.

// File: rtl/hm_ecc_pkg.sv
package hm_ecc_pkg;

  localparam int CODE_W = 24;
  localparam int PACK_W = 28;
  localparam int PAIRS  = 12;
  localparam int BYTE_W = 9;
  localparam int BIT_W  = 3;

  typedef enum logic [2:0] {
    ST_CLEAN  = 3'd0,
    ST_FIXED  = 3'd1,
    ST_CODE   = 3'd2,
    ST_UNCORR = 3'd3,
    ST_ERASED = 3'd4
  } hmStatus_e;

  typedef struct packed {
    logic capture;
    logic clearCount;
  } hmCtl_t;

  // Repack three code bytes with byte 2 split into nibbles.
  function automatic logic [PACK_W-1:0] packCode(input logic [CODE_W-1:0] code);
    return {code[23:20], code[15:8], 4'b0000, code[19:16], code[7:0]};
  endfunction

endpackage

// File: rtl/hm_ecc_datapath.sv
module hm_ecc_datapath
  import hm_ecc_pkg::*;
#(
  parameter int MAX_BLOCKS = 4,
  parameter int IDX_W      = 2,
  parameter int CNT_W      = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  hmCtl_t              ctl,
  input  logic [IDX_W-1:0]    blockIdx,
  input  logic [CODE_W-1:0]   storedCode,
  input  logic [CODE_W-1:0]   calcCode,
  output hmStatus_e           curStatus,
  output logic                resValid,
  output hmStatus_e           resStatus,
  output logic [IDX_W-1:0]    resBlock,
  output logic                fixEn,
  output logic [BYTE_W-1:0]   fixByte,
  output logic [BIT_W-1:0]    fixBit,
  output logic [CNT_W-1:0]    pageFixCount
);

  logic [PACK_W-1:0] diffPk;
  logic [CODE_W-1:0] diffC;
  logic [PAIRS-1:0]  pairOk;
  logic [PAIRS-1:0]  addrBits;
  logic              isErased;

  assign diffPk   = packCode(storedCode) ^ packCode(calcCode);
  assign diffC    = {diffPk[27:16], diffPk[11:0]};
  assign isErased = (storedCode == {CODE_W{1'b1}});

  for (genvar k = 0; k < PAIRS; k++) begin : gPair
    assign pairOk[k]   = diffC[2*k] ^ diffC[2*k+1];
    assign addrBits[k] = diffC[2*k+1];
  end

  always_comb begin
    if (diffC == '0)                   curStatus = ST_CLEAN;
    else if (isErased)                 curStatus = ST_ERASED;
    else if ($countones(diffC) == 1)   curStatus = ST_CODE;
    else if (&pairOk)                  curStatus = ST_FIXED;
    else                               curStatus = ST_UNCORR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid     <= 1'b0;
      resStatus    <= ST_CLEAN;
      resBlock     <= '0;
      fixEn        <= 1'b0;
      fixByte      <= '0;
      fixBit       <= '0;
      pageFixCount <= '0;
    end else begin
      resValid <= ctl.capture;
      if (ctl.capture) begin
        resStatus <= curStatus;
        resBlock  <= blockIdx;
        fixEn     <= (curStatus == ST_FIXED);
        fixByte   <= (curStatus == ST_FIXED) ? addrBits[11:3] : '0;
        fixBit    <= (curStatus == ST_FIXED) ? addrBits[2:0] : '0;
      end else begin
        fixEn <= 1'b0;
      end
      if (ctl.clearCount)
        pageFixCount <= '0;
      else if (ctl.capture && (curStatus == ST_FIXED || curStatus == ST_CODE))
        pageFixCount <= pageFixCount + CNT_W'(1);
    end
  end

  // R1: equal codes give a clean, uncorrected result
  p_clean_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture && (storedCode == calcCode) |=> (resStatus == ST_CLEAN) && !fixEn);

  // R5: an all-ones stored code is never corrected
  p_erased_nofix_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture && (storedCode == {CODE_W{1'b1}}) && (storedCode != calcCode)
      |=> (resStatus == ST_ERASED) && !fixEn);

  // R8: count stays within the page size
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    pageFixCount <= CNT_W'(MAX_BLOCKS));

endmodule

// File: rtl/hm_ecc_ctrl.sv
module hm_ecc_ctrl
  import hm_ecc_pkg::*;
#(
  parameter int MAX_BLOCKS = 4,
  parameter int IDX_W      = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pageStart,
  input  logic             longPage,
  input  logic             blockValid,
  input  hmStatus_e        curStatus,
  output hmCtl_t           ctl,
  output logic [IDX_W-1:0] blockIdx,
  output logic             pageDone,
  output logic             pageFail
);

  logic             active;
  logic             multi;
  logic [IDX_W-1:0] lastIdx;

  assign lastIdx        = multi ? IDX_W'(MAX_BLOCKS - 1) : '0;
  assign ctl.capture    = active && blockValid && !pageStart;
  assign ctl.clearCount = pageStart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      multi    <= 1'b0;
      blockIdx <= '0;
      pageDone <= 1'b0;
      pageFail <= 1'b0;
    end else begin
      pageDone <= 1'b0;
      pageFail <= 1'b0;
      if (pageStart) begin
        active   <= 1'b1;
        multi    <= longPage;
        blockIdx <= '0;
      end else if (ctl.capture) begin
        if (curStatus == ST_UNCORR) begin
          active   <= 1'b0;
          pageDone <= 1'b1;
          pageFail <= 1'b1;
        end else if (blockIdx == lastIdx) begin
          active   <= 1'b0;
          pageDone <= 1'b1;
        end else begin
          blockIdx <= blockIdx + IDX_W'(1);
        end
      end
    end
  end

  // R10: strobes outside a page never close one
  p_idle_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    !active && !pageStart && blockValid |=> !pageDone);

  // R9: after an abort, further strobes stay unanswered
  p_abort_closes_r9: assert property (@(posedge clk) disable iff (!rstN)
    pageFail && !pageStart |-> !ctl.capture);

endmodule

// File: rtl/hm_ecc_corrector.sv
module hm_ecc_corrector
  import hm_ecc_pkg::*;
#(
  parameter int MAX_BLOCKS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pageStart,
  input  logic        longPage,
  input  logic        blockValid,
  input  logic [23:0] storedCode,
  input  logic [23:0] calcCode,
  output logic        resValid,
  output logic [2:0]  resStatus,
  output logic [1:0]  resBlock,
  output logic        fixEn,
  output logic [8:0]  fixByte,
  output logic [2:0]  fixBit,
  output logic        pageDone,
  output logic        pageFail,
  output logic [2:0]  pageFixCount
);

  localparam int IDX_W = (MAX_BLOCKS > 1) ? $clog2(MAX_BLOCKS) : 1;
  localparam int CNT_W = $clog2(MAX_BLOCKS + 1);

  hmCtl_t            ctl;
  hmStatus_e         curStatus;
  hmStatus_e         statusQ;
  logic [IDX_W-1:0]  blockIdx;
  logic [IDX_W-1:0]  blockQ;
  logic [CNT_W-1:0]  countQ;

  hm_ecc_ctrl #(.MAX_BLOCKS(MAX_BLOCKS), .IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .pageStart(pageStart), .longPage(longPage),
    .blockValid(blockValid), .curStatus(curStatus), .ctl(ctl),
    .blockIdx(blockIdx), .pageDone(pageDone), .pageFail(pageFail)
  );

  hm_ecc_datapath #(.MAX_BLOCKS(MAX_BLOCKS), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .blockIdx(blockIdx),
    .storedCode(storedCode), .calcCode(calcCode), .curStatus(curStatus),
    .resValid(resValid), .resStatus(statusQ), .resBlock(blockQ),
    .fixEn(fixEn), .fixByte(fixByte), .fixBit(fixBit), .pageFixCount(countQ)
  );

  assign resStatus    = statusQ;
  assign resBlock     = 2'(blockQ);
  assign pageFixCount = 3'(countQ);

  // R4: a failed page is closed by an uncorrectable result
  p_fail_with_uncorr_r4: assert property (@(posedge clk) disable iff (!rstN)
    pageFail |-> pageDone && resValid && (statusQ == ST_UNCORR));

  // R6: page completion always accompanies a block result
  p_done_with_result_r6: assert property (@(posedge clk) disable iff (!rstN)
    pageDone |-> resValid);

  // R2: a correction request only comes with a fixed status
  p_fix_status_r2: assert property (@(posedge clk) disable iff (!rstN)
    fixEn |-> resValid && (statusQ == ST_FIXED));

endmodule

// File: tb/test_hm_ecc_corrector.sv
module test_hm_ecc_corrector;

  logic        clk = 1'b0;
  logic        rstN;
  logic        pageStart, longPage, blockValid;
  logic [23:0] storedCode, calcCode;
  logic        resValid, fixEn, pageDone, pageFail;
  logic [2:0]  resStatus, fixBit, pageFixCount;
  logic [1:0]  resBlock;
  logic [8:0]  fixByte;

  int nChecks = 0;
  int nFail   = 0;

  always #5 clk = ~clk;

  hm_ecc_corrector i_hm_ecc_corrector (
    .clk(clk), .rstN(rstN), .pageStart(pageStart), .longPage(longPage),
    .blockValid(blockValid), .storedCode(storedCode), .calcCode(calcCode),
    .resValid(resValid), .resStatus(resStatus), .resBlock(resBlock),
    .fixEn(fixEn), .fixByte(fixByte), .fixBit(fixBit),
    .pageDone(pageDone), .pageFail(pageFail), .pageFixCount(pageFixCount)
  );

  // kind: 0 clean, 1 fixed (aux = address), 2 code error, 3 uncorrectable, 4 erased
  localparam int NV = 9;
  localparam logic [50:0] VEC [NV] = '{
    {3'd0, 24'hA5C31E, 24'h000000},
    {3'd1, 24'h3C0F99, 24'h0005A3},
    {3'd1, 24'h000000, 24'h000000},
    {3'd1, 24'h7E8142, 24'h000FFF},
    {3'd2, 24'h12AB34, 24'h000100},
    {3'd2, 24'h12AB34, 24'h800000},
    {3'd3, 24'h55AA55, 24'h000003},
    {3'd3, 24'h010203, 24'h0F0F0F},
    {3'd4, 24'hFFFFFF, 24'h000001}
  };

  // Code-format XOR mask that encodes a single data-bit error at addr
  function automatic logic [23:0] mkMask(input logic [11:0] addr);
    logic [23:0] c;
    for (int k = 0; k < 12; k++) begin
      c[2*k+1] = addr[k];
      c[2*k]   = ~addr[k];
    end
    return {c[23:20], c[11:8], c[19:12], c[7:0]};
  endfunction

  function automatic string tagFor(input int kind);
    case (kind)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic startPage(input logic isLong);
    @(negedge clk);
    pageStart = 1'b1;
    longPage  = isLong;
    @(negedge clk);
    pageStart = 1'b0;
  endtask

  task automatic sendBlock(input logic [23:0] st, input logic [23:0] ca);
    @(negedge clk);
    blockValid = 1'b1;
    storedCode = st;
    calcCode   = ca;
    @(negedge clk);
    blockValid = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; pageStart = 1'b0; longPage = 1'b0; blockValid = 1'b0;
    storedCode = '0; calcCode = '0;
    repeat (3) @(negedge clk);
    chkEq("R11 reset resValid", int'(resValid), 0);
    chkEq("R11 reset fixEn", int'(fixEn), 0);
    chkEq("R11 reset pageDone", int'(pageDone), 0);
    chkEq("R11 reset pageFail", int'(pageFail), 0);
    chkEq("R11 reset count", int'(pageFixCount), 0);
    rstN = 1'b1;

    // R10: strobe with no open page
    sendBlock(24'h123456, 24'h654321);
    chkEq("R10 idle resValid", int'(resValid), 0);
    chkEq("R10 idle pageDone", int'(pageDone), 0);

    // Table walk: each vector as a short page
    for (int i = 0; i < NV; i++) begin
      int kind;
      logic [23:0] st, mask;
      kind = int'(VEC[i][50:48]);
      st   = VEC[i][47:24];
      mask = (kind == 1) ? mkMask(VEC[i][11:0]) : VEC[i][23:0];
      startPage(1'b0);
      chkEq("R8 cleared at start", int'(pageFixCount), 0);
      sendBlock(st, st ^ mask);
      chkEq({tagFor(kind), " resValid"}, int'(resValid), 1);
      chkEq({tagFor(kind), " status"}, int'(resStatus), kind);
      chkEq({tagFor(kind), " fixEn"}, int'(fixEn), (kind == 1) ? 1 : 0);
      if (kind == 1) begin
        chkEq("R2 fixByte", int'(fixByte), int'(VEC[i][11:3]));
        chkEq("R2 fixBit", int'(fixBit), int'(VEC[i][2:0]));
      end
      chkEq("R7 short page done", int'(pageDone), 1);
      chkEq("R7 block index", int'(resBlock), 0);
      chkEq({tagFor(kind), " pageFail"}, int'(pageFail), (kind == 3) ? 1 : 0);
      chkEq({tagFor(kind), " count"}, int'(pageFixCount), (kind == 1 || kind == 2) ? 1 : 0);
    end

    // R6, R8: long page of four blocks
    startPage(1'b1);
    sendBlock(24'h0A0B0C, 24'h0A0B0C ^ mkMask(12'h123));
    chkEq("R2 long fixByte", int'(fixByte), 36);
    chkEq("R2 long fixBit", int'(fixBit), 3);
    chkEq("R6 block0 index", int'(resBlock), 0);
    chkEq("R6 block0 no done", int'(pageDone), 0);
    @(negedge clk);
    chkEq("R11 resValid pulse", int'(resValid), 0);
    chkEq("R11 fixEn pulse", int'(fixEn), 0);
    sendBlock(24'h111111, 24'h111111);
    chkEq("R6 block1 index", int'(resBlock), 1);
    chkEq("R6 block1 no done", int'(pageDone), 0);
    sendBlock(24'h222222, 24'h222223);
    chkEq("R6 block2 index", int'(resBlock), 2);
    chkEq("R3 block2 status", int'(resStatus), 2);
    chkEq("R6 block2 no done", int'(pageDone), 0);
    sendBlock(24'hFFFFFF, 24'hFFFFFF ^ mkMask(12'h040));
    chkEq("R6 block3 index", int'(resBlock), 3);
    chkEq("R5 block3 status", int'(resStatus), 4);
    chkEq("R5 block3 fixEn", int'(fixEn), 0);
    chkEq("R6 block3 done", int'(pageDone), 1);
    chkEq("R5 page not failed", int'(pageFail), 0);
    chkEq("R8 long count", int'(pageFixCount), 2);
    @(negedge clk);
    chkEq("R11 pageDone pulse", int'(pageDone), 0);

    // R9: abort in the middle of a long page
    startPage(1'b1);
    sendBlock(24'h333333, 24'h333333 ^ 24'h000010);
    chkEq("R3 abort block0 status", int'(resStatus), 2);
    sendBlock(24'h444444, 24'h444444 ^ 24'h00000F);
    chkEq("R4 abort status", int'(resStatus), 3);
    chkEq("R4 abort done", int'(pageDone), 1);
    chkEq("R4 abort fail", int'(pageFail), 1);
    chkEq("R9 abort block index", int'(resBlock), 1);
    sendBlock(24'h555555, 24'h555555);
    chkEq("R9 ignored resValid", int'(resValid), 0);
    chkEq("R9 ignored pageDone", int'(pageDone), 0);
    chkEq("R9 count kept", int'(pageFixCount), 1);

    summary();
    $finish;
  end

endmodule